// File: doc/BRIEF.md
# Positional Vectored Interrupt Controller

This block collects interrupt requests from a fixed set of device slots and hands one of them at a time to a single interrupt-fielding processor. Each slot has its own request level and a programmed vector. A short pulse on a slot's request line makes that slot pending. The pending slot keeps its state until its vector has been delivered.

From the pending slots whose level is above the processor's current mask, the controller picks the highest level. Among slots at that level, the one with the lowest index wins, since it sits nearest the processor. The processor starts an acknowledge cycle with a strobe. The controller then freezes the winner and returns its vector on a valid/ready output stream. A stalled processor can hold off completion with ready for as long as it needs. The vector and slot number stay frozen during that time. The winner's pending bit is cleared on the handshake, and the remaining requests are arbitrated again.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irq_o, vec_valid_o and ack_done_o are 0 and no slot is pending.
- R2: A one-cycle pulse on slot_req_i[k] makes slot k pending at the next clock edge. If slot k is eligible, irq_o reads 1 from that edge on.
- R3: The 2-bit code c on slot_lvl_i[2k+1:2k] means priority level c+1, from 1 to 4. A pending slot is eligible only when c+1 > cpu_mask_i. A masked slot stays pending and raises irq_o as soon as the mask is lowered.
- R4: When eligible slots sit at different levels, the slot at the highest level is granted.
- R5: Among eligible slots at the same level, the lowest slot index is granted.
- R6: An iak_i pulse sampled while irq_o is 1 starts an acknowledge. After that edge, vec_valid_o is 1 and gnt_slot_o holds the winner's index. vec_o holds bits [15:2] of the winner's slot_vec_i[16k+15:16k], with bits [1:0] forced to 0.
- R7: Changes to requests, levels or vectors during an acknowledge do not alter vec_o or gnt_slot_o.
- R8: vec_valid_o, vec_o and gnt_slot_o hold until vec_ready_i is 1. ack_done_o equals vec_valid_o AND vec_ready_i, and there is one delivery per acknowledge.
- R9: On the handshake, the granted slot's pending bit clears and all other pending slots are kept. After that edge, irq_o reflects the remaining pending slots.
- R10: irq_o is 0 while vec_valid_o is 1. An iak_i sampled while irq_o is 0 starts nothing.
- R11: A request pulse on the granted slot in the handshake cycle takes priority over the clear, so the slot stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req_i | input | NUM_SLOTS | Per-slot request pulse |
| slot_lvl_i | input | 2*NUM_SLOTS | Per-slot level code, 2 bits each |
| slot_vec_i | input | VEC_W*NUM_SLOTS | Per-slot programmed vector |
| cpu_mask_i | input | 3 | Processor's current priority mask |
| iak_i | input | 1 | Acknowledge start strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector stream valid |
| vec_ready_i | input | 1 | Vector stream ready |
| vec_o | output | VEC_W | Delivered vector, low two bits zero |
| gnt_slot_o | output | $clog2(NUM_SLOTS) | Granted slot index |
| ack_done_o | output | 1 | Vector delivered this cycle |

## Verification
irq_o is combinational from the registered pending bits and the live mask, so it is due one edge after a request pulse, or at once after a mask change. The vector, slot index and valid flag appear one edge after the acknowledge strobe is sampled. ack_done_o is combinational with vec_ready_i in the same cycle, and the pending clear and the return of irq_o follow one edge after the handshake. The bench drives inputs one time unit after a rising edge and checks after a further settling delay, so each result is read in exactly the cycle these counts predict.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_LEVELS = 4;
  localparam int LVL_W      = $clog2(NUM_LEVELS);
  localparam int MASK_W     = LVL_W + 1;

  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_HOLD = 1'b1
  } ack_state_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  output logic [NUM_SLOTS-1:0] pending_o
);
  logic [NUM_SLOTS-1:0] pending_q;

  // set wins over clear for the same slot
  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= (pending_q & ~clr_i) | set_i;
  end

  assign pending_o = pending_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pending_q & $past(set_i)) == $past(set_i))); // R11

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pending_q & $past(clr_i & ~set_i)) == '0)); // R9
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import vec_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       pending_i,
  input  logic [LVL_W*NUM_SLOTS-1:0] lvl_i,
  input  logic [MASK_W-1:0]          mask_i,
  output logic                       any_o,
  output logic [IDX_W-1:0]           win_idx_o
);
  logic [NUM_SLOTS-1:0] eligible;

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_elig
      logic [MASK_W-1:0] prio;
      assign prio        = MASK_W'(lvl_i[g*LVL_W +: LVL_W]) + MASK_W'(1);
      assign eligible[g] = pending_i[g] && (prio > mask_i);
    end
  endgenerate

  // scan from the far end; ">=" lets a nearer slot take ties
  logic [LVL_W-1:0] best_lvl;
  always_comb begin
    any_o     = 1'b0;
    win_idx_o = '0;
    best_lvl  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eligible[i] && (!any_o || lvl_i[i*LVL_W +: LVL_W] >= best_lvl)) begin
        any_o     = 1'b1;
        win_idx_o = IDX_W'(i);
        best_lvl  = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pending_i[win_idx_o]); // R4

  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i == '0) |-> !any_o); // R3
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import vec_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     win_idx_i,
  input  logic [VEC_W-1:0]     win_vec_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [IDX_W-1:0]     gnt_o,
  output logic                 done_o,
  output logic [NUM_SLOTS-1:0] clr_o
);
  ack_state_e           state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [VEC_W-1:0]     vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      idx_q   <= '0;
      vec_q   <= '0;
    end else begin
      case (state_q)
        ACK_IDLE: if (start_i) begin
          state_q <= ACK_HOLD;
          idx_q   <= win_idx_i;
          vec_q   <= {win_vec_i[VEC_W-1:2], 2'b00};
        end
        ACK_HOLD: if (ready_i) state_q <= ACK_IDLE;
        default:  state_q <= ACK_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ACK_HOLD);
  assign vec_o   = vec_q;
  assign gnt_o   = idx_q;
  assign done_o  = valid_o && ready_i;

  always_comb begin
    clr_o = '0;
    if (done_o) clr_o[idx_q] = 1'b1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(vec_o) && $stable(gnt_o))); // R8

  AST_ONE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !valid_o); // R8

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(start_i)); // R6
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS-1:0]       slot_req_i,
  input  logic [LVL_W*NUM_SLOTS-1:0] slot_lvl_i,
  input  logic [VEC_W*NUM_SLOTS-1:0] slot_vec_i,
  input  logic [MASK_W-1:0]          cpu_mask_i,
  input  logic                       iak_i,
  output logic                       irq_o,
  output logic                       vec_valid_o,
  input  logic                       vec_ready_i,
  output logic [VEC_W-1:0]           vec_o,
  output logic [IDX_W-1:0]           gnt_slot_o,
  output logic                       ack_done_o
);
  logic [NUM_SLOTS-1:0] pending;
  logic [NUM_SLOTS-1:0] clr;
  logic                 any;
  logic [IDX_W-1:0]     win_idx;
  logic                 start;

  irq_pending #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(slot_req_i), .clr_i(clr), .pending_o(pending)
  );

  irq_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .lvl_i(slot_lvl_i),
    .mask_i(cpu_mask_i), .any_o(any), .win_idx_o(win_idx)
  );

  assign irq_o = any && !vec_valid_o;
  assign start = iak_i && irq_o;

  irq_ack_fsm #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .start_i(start), .win_idx_i(win_idx),
    .win_vec_i(slot_vec_i[win_idx*VEC_W +: VEC_W]), .ready_i(vec_ready_i),
    .valid_o(vec_valid_o), .vec_o(vec_o), .gnt_o(gnt_slot_o),
    .done_o(ack_done_o), .clr_o(clr)
  );

  AST_QUIET_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> !irq_o); // R10

  AST_IAK_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (iak_i && !irq_o && !vec_valid_o) |=> !vec_valid_o); // R10
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 8;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  slot_req_i;
  logic [2*N-1:0] slot_lvl_i;
  logic [VW*N-1:0] slot_vec_i;
  logic [2:0]    cpu_mask_i;
  logic          iak_i;
  logic          irq_o;
  logic          vec_valid_o;
  logic          vec_ready_i;
  logic [VW-1:0] vec_o;
  logic [2:0]    gnt_slot_o;
  logic          ack_done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .slot_req_i(slot_req_i), .slot_lvl_i(slot_lvl_i),
    .slot_vec_i(slot_vec_i), .cpu_mask_i(cpu_mask_i), .iak_i(iak_i), .irq_o(irq_o),
    .vec_valid_o(vec_valid_o), .vec_ready_i(vec_ready_i), .vec_o(vec_o),
    .gnt_slot_o(gnt_slot_o), .ack_done_o(ack_done_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int k);
    return 16'h0100 + 16'(k * 4);
  endfunction

  task automatic set_lvl(input int k, input logic [1:0] c);
    slot_lvl_i[k*2 +: 2] = c;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    slot_req_i = m;
    step();
    slot_req_i = '0;
    #1;
  endtask

  task automatic serve(input int k, input logic [15:0] v, input string req);
    iak_i = 1'b1;
    step();
    iak_i = 1'b0;
    #1;
    check({req, " valid"}, 32'(vec_valid_o), 1);
    check({req, " slot"}, 32'(gnt_slot_o), 32'(k));
    check({req, " vector"}, 32'(vec_o), 32'(v));
    vec_ready_i = 1'b1;
    #1;
    check("R8 done", 32'(ack_done_o), 1);
    step();
    vec_ready_i = 1'b0;
    #1;
    check("R8 valid drop", 32'(vec_valid_o), 0);
  endtask

  task automatic t_reset();
    check("R1 irq", 32'(irq_o), 0);
    check("R1 valid", 32'(vec_valid_o), 0);
    check("R1 done", 32'(ack_done_o), 0);
  endtask

  task automatic t_single();
    set_lvl(3, 2'd1);
    pulse_req(8'h08);
    check("R2 irq", 32'(irq_o), 1);
    serve(3, exp_vec(3), "R6");
    check("R9 irq after", 32'(irq_o), 0);
  endtask

  task automatic t_mask();
    set_lvl(5, 2'd1);
    cpu_mask_i = 3'd2;
    pulse_req(8'h20);
    check("R3 masked", 32'(irq_o), 0);
    cpu_mask_i = 3'd1;
    #1;
    check("R3 unmasked", 32'(irq_o), 1);
    serve(5, exp_vec(5), "R3");
    cpu_mask_i = 3'd0;
  endtask

  task automatic t_levels();
    set_lvl(6, 2'd3);
    set_lvl(1, 2'd0);
    pulse_req(8'h42);
    serve(6, exp_vec(6), "R4");
    check("R9 kept", 32'(irq_o), 1);
    serve(1, exp_vec(1), "R9");
  endtask

  task automatic t_position();
    set_lvl(2, 2'd2);
    set_lvl(4, 2'd2);
    set_lvl(7, 2'd2);
    pulse_req(8'h94);
    serve(2, exp_vec(2), "R5");
    serve(4, exp_vec(4), "R5");
    serve(7, exp_vec(7), "R5");
    check("R9 empty", 32'(irq_o), 0);
  endtask

  task automatic t_latch();
    set_lvl(0, 2'd1);
    set_lvl(1, 2'd3);
    pulse_req(8'h01);
    iak_i = 1'b1;
    step();
    iak_i = 1'b0;
    slot_vec_i[0 +: 16] = 16'hBEEF;
    slot_req_i = 8'h02;
    step();
    slot_req_i = '0;
    iak_i = 1'b1;
    step();
    iak_i = 1'b0;
    #1;
    check("R7 vector frozen", 32'(vec_o), 32'(exp_vec(0)));
    check("R7 slot frozen", 32'(gnt_slot_o), 0);
    check("R8 held", 32'(vec_valid_o), 1);
    check("R10 irq low", 32'(irq_o), 0);
    check("R8 no done", 32'(ack_done_o), 0);
    vec_ready_i = 1'b1;
    #1;
    check("R8 done", 32'(ack_done_o), 1);
    step();
    vec_ready_i = 1'b0;
    #1;
    check("R10 one delivery", 32'(vec_valid_o), 0);
    check("R9 next", 32'(irq_o), 1);
    serve(1, exp_vec(1), "R9");
    check("R9 slot0 cleared", 32'(irq_o), 0);
    slot_vec_i[0 +: 16] = 16'h0103;
  endtask

  task automatic t_set_wins();
    set_lvl(2, 2'd2);
    pulse_req(8'h04);
    iak_i = 1'b1;
    step();
    iak_i = 1'b0;
    vec_ready_i = 1'b1;
    slot_req_i = 8'h04;
    step();
    vec_ready_i = 1'b0;
    slot_req_i = '0;
    #1;
    check("R11 still pending", 32'(irq_o), 1);
    serve(2, exp_vec(2), "R11");
  endtask

  task automatic t_iak_ignored();
    set_lvl(3, 2'd0);
    cpu_mask_i = 3'd7;
    pulse_req(8'h08);
    iak_i = 1'b1;
    step();
    iak_i = 1'b0;
    #1;
    check("R10 iak ignored", 32'(vec_valid_o), 0);
    cpu_mask_i = 3'd0;
    #1;
    check("R3 released", 32'(irq_o), 1);
    serve(3, exp_vec(3), "R10");
  endtask

  initial begin
    rst_n = 1'b0;
    slot_req_i = '0;
    slot_lvl_i = '0;
    cpu_mask_i = '0;
    iak_i = 1'b0;
    vec_ready_i = 1'b0;
    for (int k = 0; k < N; k++) slot_vec_i[k*16 +: 16] = 16'h0100 + 16'(k * 4) + 16'd3;
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_mask();
    t_levels();
    t_position();
    t_latch();
    t_set_wins();
    t_iak_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule